// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 active-high, level-sensitive interrupt lines into two processor request outputs: a normal request and a fast request. Each source line is ORed with a software-assert bit that software owns. The result is gated by a per-source enable. A per-source route bit then sends it to either the normal or the fast output. Software talks to the block over a simple register bus. A write takes effect at a clock edge. A read returns data combinationally for the address presented.

Software can read the unmasked source word and the two masked status words. It sets enables through one register and clears them through another, using write-one semantics in both. Software interrupts are raised and dropped the same way. A guard bit makes the block ignore every write that carries the user-mode flag, so unprivileged code cannot change the interrupt setup.

Top module: `mmio_int_ctrl`

## Requirements
- R1: After reset, all enable, route, software-assert and guard bits are 0, every readable register returns 0 while no source line is high, and both request outputs are low.
- R2: The raw word at offset 0x08 shows, per source, the OR of the source line and its software-assert bit, whatever the enable bit holds.
- R3: The normal status word at offset 0x00 is raw AND enable AND NOT route. The fast status word at offset 0x04 is raw AND enable AND route.
- R4: The route word at offset 0x0C is read/write and each write overwrites it fully. A route bit of 1 sends its source to the fast output and a 0 sends it to the normal output.
- R5: Writing to offset 0x10 sets the enable bits written as 1 and leaves the others unchanged. Reading 0x10 returns the enable word.
- R6: Writing to offset 0x14 clears the enable bits written as 1 and leaves the others unchanged. Reading 0x14 returns 0.
- R7: Writing to offset 0x18 sets the software-assert bits written as 1. Writing to offset 0x1C clears the bits written as 1. Reading 0x18 returns the software-assert word and reading 0x1C returns 0.
- R8: Bit 0 of offset 0x20 is the guard bit and reads back in bit 0. While it is 1, any write with the user flag high changes no register, including the guard itself. Writes with the user flag low still take effect.
- R9: The normal request output is the OR of the normal status word and the fast request output is the OR of the fast status word, each one clock cycle later.
- R10: Status follows the source level. A status bit stays 1 for as long as its line is high (enabled, no software bit) and returns to 0 once the line drops.
- R11: Reads of unmapped offsets return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_addr | input | 8 | Byte offset for a read or write |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_user | input | 1 | Marks the write as coming from user mode |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Two events can land in the same cycle: a hardware line changing level and a software write to the same source's state. The bench provokes this in two ways. First, it clears a software-assert bit while that source's line is still high, and checks that the raw and status bits stay at 1 and the normal request stays up. Second, it raises a source line in the same cycle as an enable-clear write for that source, and checks that both the status bit and the request output are 0 once the edge has passed. A table of routing and mask patterns then checks all three status words and both outputs against values worked out by hand.

// File: rtl/mic_pkg.sv
package mic_pkg;

   localparam int unsigned OFF_IRQ_ST  = 32'h00;
   localparam int unsigned OFF_FIQ_ST  = 32'h04;
   localparam int unsigned OFF_RAW     = 32'h08;
   localparam int unsigned OFF_ROUTE   = 32'h0C;
   localparam int unsigned OFF_EN_SET  = 32'h10;
   localparam int unsigned OFF_EN_CLR  = 32'h14;
   localparam int unsigned OFF_SW_SET  = 32'h18;
   localparam int unsigned OFF_SW_CLR  = 32'h1C;
   localparam int unsigned OFF_GUARD   = 32'h20;

   localparam int unsigned MIN_ADDR_W  = 6;

   typedef struct packed {
      logic route;
      logic en_set;
      logic en_clr;
      logic sw_set;
      logic sw_clr;
      logic guard;
   } mic_wstb_t;

endpackage

// File: rtl/mic_bus_decode.sv
module mic_bus_decode
   import mic_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              user,
   input  logic              guard_q,
   output mic_wstb_t         stb
);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("mic_bus_decode: ADDR_W too small for register map");
   end

   logic wr_ok;

   assign wr_ok = wr && !(guard_q && user);

   always_comb begin
      stb = '0;
      if (wr_ok) begin
         stb.route  = (addr == ADDR_W'(OFF_ROUTE));
         stb.en_set = (addr == ADDR_W'(OFF_EN_SET));
         stb.en_clr = (addr == ADDR_W'(OFF_EN_CLR));
         stb.sw_set = (addr == ADDR_W'(OFF_SW_SET));
         stb.sw_clr = (addr == ADDR_W'(OFF_SW_CLR));
         stb.guard  = (addr == ADDR_W'(OFF_GUARD));
      end
   end

   AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_q && user) |-> (stb == '0)); // R8

   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb)); // R11

endmodule

// File: rtl/mic_src_lane.sv
module mic_src_lane
   import mic_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      src_i,
   input  mic_wstb_t stb,
   input  logic      wbit,
   output logic      en_q,
   output logic      route_q,
   output logic      sw_q,
   output logic      raw,
   output logic      irq_st,
   output logic      fiq_st
);

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("mic_src_lane: SYNC_STAGES above 4 not supported");
   end

   logic lvl;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = src_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2+1-1:0], src_i} >> 0;
      end
      assign lvl = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         route_q <= 1'b0;
         sw_q    <= 1'b0;
      end else begin
         if (stb.route) route_q <= wbit;
         if (stb.en_set && wbit)      en_q <= 1'b1;
         else if (stb.en_clr && wbit) en_q <= 1'b0;
         if (stb.sw_set && wbit)      sw_q <= 1'b1;
         else if (stb.sw_clr && wbit) sw_q <= 1'b0;
      end
   end

   assign raw    = lvl | sw_q;
   assign irq_st = raw & en_q & ~route_q;
   assign fiq_st = raw & en_q &  route_q;

   AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.en_set && wbit) |=> en_q); // R5

   AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.en_clr && wbit) |=> !en_q); // R6

   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb.en_set || stb.en_clr) |=> $stable(en_q)); // R5

   AST_SW_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.sw_clr && wbit) |=> !sw_q); // R7

   AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.route |=> $stable(route_q)); // R4

endmodule

// File: rtl/mic_req_merge.sv
module mic_req_merge #(
   parameter int unsigned NUM_SRC = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_vec,
   input  logic [NUM_SRC-1:0] fiq_vec,
   output logic               irq_o,
   output logic               fiq_o
);

   logic irq_any;
   logic fiq_any;

   assign irq_any = |irq_vec;
   assign fiq_any = |fiq_vec;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
         end else begin
            irq_o <= irq_any;
            fiq_o <= fiq_any;
         end
      end

      AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (irq_o == $past(irq_any))); // R9

      AST_FIQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (fiq_o == $past(fiq_any))); // R9
   end else begin : g_comb
      assign irq_o = irq_any;
      assign fiq_o = fiq_any;
   end

endmodule

// File: rtl/mmio_int_ctrl.sv
module mmio_int_ctrl
   import mic_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_user,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o,
   output logic               fiq_o
);

   if (NUM_SRC > DATA_W || NUM_SRC == 0) begin : g_bad_num_src
      $error("mmio_int_ctrl: NUM_SRC must be 1..DATA_W");
   end

   mic_wstb_t          stb;
   logic               guard_q;
   logic [NUM_SRC-1:0] en_w, route_w, sw_w, raw_w, irq_w, fiq_w;

   mic_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .user    (bus_user),
      .guard_q (guard_q),
      .stb     (stb)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      mic_src_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (src_i[i]),
         .stb     (stb),
         .wbit    (bus_wdata[i]),
         .en_q    (en_w[i]),
         .route_q (route_w[i]),
         .sw_q    (sw_w[i]),
         .raw     (raw_w[i]),
         .irq_st  (irq_w[i]),
         .fiq_st  (fiq_w[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         guard_q <= 1'b0;
      else if (stb.guard) guard_q <= bus_wdata[0];
   end

   mic_req_merge #(.NUM_SRC(NUM_SRC), .OUT_REG(OUT_REG)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_vec (irq_w),
      .fiq_vec (fiq_w),
      .irq_o   (irq_o),
      .fiq_o   (fiq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == ADDR_W'(OFF_IRQ_ST)) bus_rdata = DATA_W'(irq_w);
      else if (bus_addr == ADDR_W'(OFF_FIQ_ST)) bus_rdata = DATA_W'(fiq_w);
      else if (bus_addr == ADDR_W'(OFF_RAW))    bus_rdata = DATA_W'(raw_w);
      else if (bus_addr == ADDR_W'(OFF_ROUTE))  bus_rdata = DATA_W'(route_w);
      else if (bus_addr == ADDR_W'(OFF_EN_SET)) bus_rdata = DATA_W'(en_w);
      else if (bus_addr == ADDR_W'(OFF_SW_SET)) bus_rdata = DATA_W'(sw_w);
      else if (bus_addr == ADDR_W'(OFF_GUARD))  bus_rdata = DATA_W'(guard_q);
   end

   AST_GUARD_FREEZES_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_q && bus_wr && bus_user) |=> $stable(en_w)); // R8

   AST_GUARD_SELF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_q && bus_wr && bus_user) |=> guard_q); // R8

   AST_ROUTES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_w & fiq_w) == '0); // R3

endmodule

// File: tb/sim_mmio_int_ctrl.sv
module sim_mmio_int_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_user = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mmio_int_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_user(bus_user),
      .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   typedef struct packed {
      logic [31:0] src, en, route, sw, raw, irq, fiq;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{32'h0000_00F0, 32'h0000_00FF, 32'h0000_000F, 32'h0,
        32'h0000_00F0, 32'h0000_00F0, 32'h0},
      '{32'h0, 32'hFFFF_0000, 32'hFF00_0000, 32'h0301_0001,
        32'h0301_0001, 32'h0001_0000, 32'h0300_0000},
      '{32'h8000_0001, 32'h0, 32'h0, 32'h0,
        32'h8000_0001, 32'h0, 32'h0},
      '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555,
        32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF},
      '{32'h1234_5678, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h0,
        32'h1234_5678, 32'h0200_0600, 32'h0004_0008},
      '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic usr);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_user = usr; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_user = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a <= 8'h20; a += 4) begin
         rd(8'(a), v);
         chk($sformatf("R1 reset read %0h", a), v, 32'h0);
      end
      chk("R1 irq_o/fiq_o after reset", {30'b0, irq_o, fiq_o}, 32'h0);

      // table walk: R2 R3 R4 R9
      for (int k = 0; k < 6; k++) begin
         wr(8'h14, 32'hFFFF_FFFF, 1'b0);
         wr(8'h1C, 32'hFFFF_FFFF, 1'b0);
         src_i = VECS[k].src;
         wr(8'h0C, VECS[k].route, 1'b0);
         wr(8'h10, VECS[k].en, 1'b0);
         wr(8'h18, VECS[k].sw, 1'b0);
         rd(8'h08, v); chk($sformatf("R2 raw vec%0d", k), v, VECS[k].raw);
         rd(8'h00, v); chk($sformatf("R3 irq status vec%0d", k), v, VECS[k].irq);
         rd(8'h04, v); chk($sformatf("R3 fiq status vec%0d", k), v, VECS[k].fiq);
         rd(8'h0C, v); chk($sformatf("R4 route vec%0d", k), v, VECS[k].route);
         @(negedge clk);
         chk($sformatf("R9 outputs vec%0d", k), {30'b0, irq_o, fiq_o},
             {30'b0, |VECS[k].irq, |VECS[k].fiq});
      end

      // clean slate
      src_i = '0;
      wr(8'h14, 32'hFFFF_FFFF, 1'b0);
      wr(8'h1C, 32'hFFFF_FFFF, 1'b0);
      wr(8'h0C, 32'h0, 1'b0);

      // R5 enable set only sets
      wr(8'h10, 32'h3, 1'b0);
      wr(8'h10, 32'h4, 1'b0);
      rd(8'h10, v); chk("R5 enable accumulates", v, 32'h7);
      // R6 enable clear
      wr(8'h14, 32'h1, 1'b0);
      rd(8'h10, v); chk("R6 enable clear one bit", v, 32'h6);
      wr(8'h14, 32'h0, 1'b0);
      rd(8'h10, v); chk("R6 zero clear no effect", v, 32'h6);
      rd(8'h14, v); chk("R6 clear reg reads 0", v, 32'h0);

      // R4 overwrite
      wr(8'h0C, 32'hF0, 1'b0);
      wr(8'h0C, 32'h0F, 1'b0);
      rd(8'h0C, v); chk("R4 route overwrite", v, 32'h0F);
      wr(8'h0C, 32'h0, 1'b0);

      // R7 software assert
      wr(8'h18, 32'h10, 1'b0);
      wr(8'h18, 32'h01, 1'b0);
      rd(8'h18, v); chk("R7 soft set", v, 32'h11);
      wr(8'h1C, 32'h10, 1'b0);
      rd(8'h18, v); chk("R7 soft clear", v, 32'h01);
      rd(8'h1C, v); chk("R7 soft clear reads 0", v, 32'h0);
      wr(8'h1C, 32'h01, 1'b0);

      // R9 R10 timing and level (enable bit 1 already set)
      @(negedge clk);
      src_i[1] = 1'b1;
      rd(8'h00, v); chk("R10 status follows line high", v, 32'h2);
      chk("R9 irq_o not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R9 irq_o one cycle later", {31'b0, irq_o}, 32'h1);
      repeat (3) @(negedge clk);
      rd(8'h00, v); chk("R10 status holds while high", v, 32'h2);
      src_i[1] = 1'b0;
      rd(8'h00, v); chk("R10 status drops with line", v, 32'h0);
      chk("R9 irq_o still high", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R9 irq_o falls one cycle later", {31'b0, irq_o}, 32'h0);

      // same cycle: soft clear while hardware line high (bit 2 enabled)
      src_i[2] = 1'b1;
      wr(8'h18, 32'h4, 1'b0);
      wr(8'h1C, 32'h4, 1'b0);
      rd(8'h08, v); chk("R2 raw held by line after soft clear", v & 32'h4, 32'h4);
      rd(8'h00, v); chk("R7 status kept by line", v, 32'h4);
      chk("R9 irq_o stays up", {31'b0, irq_o}, 32'h1);
      src_i[2] = 1'b0;

      // same cycle: line rises with enable-clear write
      @(negedge clk);
      bus_addr = 8'h14; bus_wdata = 32'h4; bus_wr = 1'b1; src_i[2] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(8'h00, v); chk("R6 cleared source gives no status", v, 32'h0);
      @(negedge clk);
      chk("R6 no request after clear", {31'b0, irq_o}, 32'h0);
      src_i[2] = 1'b0;

      // R8 guard
      wr(8'h20, 32'h1, 1'b0);
      rd(8'h20, v); chk("R8 guard readback", v, 32'h1);
      wr(8'h10, 32'h100, 1'b1);
      rd(8'h10, v); chk("R8 user enable blocked", v, 32'h2);
      wr(8'h18, 32'h100, 1'b1);
      rd(8'h18, v); chk("R8 user soft blocked", v, 32'h0);
      wr(8'h20, 32'h0, 1'b1);
      rd(8'h20, v); chk("R8 user cannot drop guard", v, 32'h1);
      wr(8'h10, 32'h100, 1'b0);
      rd(8'h10, v); chk("R8 privileged write passes", v, 32'h102);
      wr(8'h20, 32'h0, 1'b0);
      wr(8'h14, 32'h100, 1'b1);
      rd(8'h10, v); chk("R8 user write allowed when off", v, 32'h2);

      // R11 unmapped
      wr(8'h24, 32'hFFFF_FFFF, 1'b0);
      wr(8'h30, 32'hFFFF_FFFF, 1'b0);
      rd(8'h24, v); chk("R11 unmapped read 0x24", v, 32'h0);
      rd(8'h30, v); chk("R11 unmapped read 0x30", v, 32'h0);
      rd(8'h10, v); chk("R11 enable untouched", v, 32'h2);
      rd(8'h18, v); chk("R11 soft untouched", v, 32'h0);
      rd(8'h0C, v); chk("R11 route untouched", v, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule